// File: doc/BRIEF.md
# Asynchronous External Memory Cycle Sequencer

This block turns simple internal read and write requests into timed bus cycles for asynchronous static RAM, NOR flash or NAND parts. The host raises a request with an address, a direction flag and write data. The block picks one of four chip selects from the two top address bits. It then runs the cycle as three phases: setup, strobe and hold. When the cycle is over it returns read data with a one-cycle ready pulse.

Each chip select has its own configuration, given as static inputs. The configuration holds separate read and write cycle counts for each phase, a turnaround count, the bus width (8 or 16 bits), a select-strobe flag and an extended-wait flag. Turnaround cycles are added only when the direction or the chip select changes from the previous access. An external wait line can stretch the strobe phase. That line passes through a two-flop synchronizer before it is used.

Top module: `amc_async_mem`

## Requirements
- R1: Address bits [27:26] select chip select 0..3. During an access exactly that active-low mem_cs_n bit goes low and the other bits stay high.
- R2: Every access runs setup, then strobe, then hold. A read asserts mem_oe_n low only in strobe, and a write asserts mem_we_n low only in strobe. The phase lengths come from the read or write counts of the selected chip select.
- R3: A programmed phase count of zero gives a phase of exactly one cycle.
- R4: A request seen in an idle cycle starts setup in the next cycle. The exception is when the direction or the chip select differs from the previous access: then T idle turnaround cycles come first, where T is the turnaround count of the previous access's chip select. There is no turnaround for the first access after reset, and none when T is 0.
- R5: With select-strobe mode set, the chip select is low only in strobe cycles, while setup and hold keep their lengths.
- R6: With extended wait set, the strobe ends on the first cycle in which the programmed count has expired and the two-flop-synchronized wait bit of that chip select is low. If wait is released in strobe cycle j, the strobe lasts max(count, j+2) cycles. With the mode clear, wait has no effect.
- R7: Bus width flag 1 selects 16 bits: mem_addr is the window byte offset shifted right by one. Flag 0 selects 8 bits: mem_addr is the byte offset, only data bits [7:0] are driven on writes, and the upper byte of read data returns zero.
- R8: Chip select and address stay stable from the first setup cycle through the last hold cycle. Write data is driven over that whole span, and the block never drives the data bus while mem_oe_n is low.
- R9: Read data is captured in the final strobe cycle. host_rdy pulses high for exactly one cycle, in the cycle right after the last hold cycle, with the read data valid.
- R10: After reset all chip selects, mem_oe_n and mem_we_n are high, and host_rdy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until host_rdy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 28 | Byte address; [27:26] pick the chip select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rdy |
| host_rdy | output | 1 | One-cycle completion pulse |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable (write strobe) |
| mem_addr | output | 26 | Device address |
| mem_data | inout | 16 | Device data bus |
| mem_wait | input | 4 | Wait line per chip select, active high |
| cfg_rd_setup | input | 16 | Read setup count, 4 bits per chip select |
| cfg_rd_strobe | input | 16 | Read strobe count, 4 bits per chip select |
| cfg_rd_hold | input | 16 | Read hold count, 4 bits per chip select |
| cfg_wr_setup | input | 16 | Write setup count, 4 bits per chip select |
| cfg_wr_strobe | input | 16 | Write strobe count, 4 bits per chip select |
| cfg_wr_hold | input | 16 | Write hold count, 4 bits per chip select |
| cfg_turn | input | 16 | Turnaround count, 4 bits per chip select |
| cfg_wide | input | 4 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_sel_strobe | input | 4 | Select-strobe mode per chip select |
| cfg_ext_wait | input | 4 | Extended-wait mode per chip select |

## Verification
A phase counter that is off by one, or a wrong phase state, shows up at once at the device pins as one cycle more or less of mem_cs_n low around the strobe. It also moves the ready pulse by the same cycle within that access. A stale record of the previous access shows up only on the next request: the gap before its first setup cycle gains or loses turnaround cycles. A wrong synchronizer depth or a wrong wait-bit selection stretches or shortens the strobe by whole cycles in the access that uses it.

// File: rtl/amc_pkg.sv
package amc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_TURN   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4,
      PH_DONE   = 3'd5
   } phase_t;
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   logic [N-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/amc_cfg_sel.sv
module amc_cfg_sel #(
   parameter int NCS   = 4,
   parameter int CNT_W = 4,
   localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic                 we,
   input  logic [NCS*CNT_W-1:0] rd_setup,
   input  logic [NCS*CNT_W-1:0] rd_strobe,
   input  logic [NCS*CNT_W-1:0] rd_hold,
   input  logic [NCS*CNT_W-1:0] wr_setup,
   input  logic [NCS*CNT_W-1:0] wr_strobe,
   input  logic [NCS*CNT_W-1:0] wr_hold,
   input  logic [NCS*CNT_W-1:0] turn,
   input  logic [NCS-1:0]       wide,
   input  logic [NCS-1:0]       sel_strobe,
   input  logic [NCS-1:0]       ext_wait,
   output logic [CNT_W-1:0]     setup_lim,
   output logic [CNT_W-1:0]     strobe_lim,
   output logic [CNT_W-1:0]     hold_lim,
   output logic [CNT_W-1:0]     turn_cnt,
   output logic                 is_wide,
   output logic                 is_ss,
   output logic                 is_ew
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] raw_su, raw_st, raw_ho;

   // pick the field set of the direction, then clamp zero to one cycle
   always_comb begin
      raw_su = we ? wr_setup [sel*CNT_W +: CNT_W] : rd_setup [sel*CNT_W +: CNT_W];
      raw_st = we ? wr_strobe[sel*CNT_W +: CNT_W] : rd_strobe[sel*CNT_W +: CNT_W];
      raw_ho = we ? wr_hold  [sel*CNT_W +: CNT_W] : rd_hold  [sel*CNT_W +: CNT_W];
      setup_lim  = (raw_su == '0) ? ONE : raw_su;
      strobe_lim = (raw_st == '0) ? ONE : raw_st;
      hold_lim   = (raw_ho == '0) ? ONE : raw_ho;
      turn_cnt   = turn[sel*CNT_W +: CNT_W];
      is_wide    = wide[sel];
      is_ss      = sel_strobe[sel];
      is_ew      = ext_wait[sel];
   end
endmodule

// File: rtl/amc_seq_fsm.sv
module amc_seq_fsm
   import amc_pkg::*;
#(
   parameter int NCS      = 4,
   parameter int CNT_W    = 4,
   parameter int WIN_BITS = 26,
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                req_we,
   input  logic [SEL_W-1:0]    req_cs,
   input  logic [WIN_BITS-1:0] req_off,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [CNT_W-1:0]    setup_lim,
   input  logic [CNT_W-1:0]    strobe_lim,
   input  logic [CNT_W-1:0]    hold_lim,
   input  logic [CNT_W-1:0]    turn_cnt,
   input  logic                is_wide,
   input  logic                is_ss,
   input  logic                is_ew,
   input  logic [NCS-1:0]      wait_s,
   input  logic [DATA_W-1:0]   din,
   output logic [SEL_W-1:0]    cs_q,
   output logic                we_q,
   output phase_t              phase,
   output logic [NCS-1:0]      cs_n,
   output logic                oe_n,
   output logic                wen_n,
   output logic [WIN_BITS-1:0] addr,
   output logic [DATA_W-1:0]   dout,
   output logic                drv_lo,
   output logic                drv_hi,
   output logic [DATA_W-1:0]   rdata,
   output logic                rdy
);
   logic [CNT_W-1:0]    cnt_q, turn_q;
   logic [WIN_BITS-1:0] off_q;
   logic                have_prev;
   logic                in_cyc, cs_act, stb_done;

   assign stb_done = (cnt_q >= strobe_lim - 1'b1) && !(is_ew && wait_s[cs_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt_q     <= '0;
         turn_q    <= '0;
         cs_q      <= '0;
         we_q      <= 1'b0;
         off_q     <= '0;
         dout      <= '0;
         rdata     <= '0;
         have_prev <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: if (req) begin
               cs_q      <= req_cs;
               we_q      <= req_we;
               off_q     <= req_off;
               dout      <= req_wdata;
               have_prev <= 1'b1;
               cnt_q     <= '0;
               turn_q    <= turn_cnt;   // still the previous access's chip select
               if (have_prev && (req_cs != cs_q || req_we != we_q) && turn_cnt != '0)
                  phase <= PH_TURN;
               else
                  phase <= PH_SETUP;
            end
            PH_TURN: if (cnt_q == turn_q - 1'b1) begin
               phase <= PH_SETUP;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_SETUP: if (cnt_q == setup_lim - 1'b1) begin
               phase <= PH_STROBE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_STROBE: if (stb_done) begin
               phase <= PH_HOLD;
               cnt_q <= '0;
               if (!we_q)
                  rdata <= is_wide ? din
                                   : {{(DATA_W-NARROW_W){1'b0}}, din[NARROW_W-1:0]};
            end else if (cnt_q < strobe_lim - 1'b1) cnt_q <= cnt_q + 1'b1;
            PH_HOLD: if (cnt_q == hold_lim - 1'b1) begin
               phase <= PH_DONE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      in_cyc = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
      cs_act = is_ss ? (phase == PH_STROBE) : in_cyc;
      cs_n   = ~(NCS'(cs_act) << cs_q);
      oe_n   = !((phase == PH_STROBE) && !we_q);
      wen_n  = !((phase == PH_STROBE) && we_q);
      addr   = is_wide ? {1'b0, off_q[WIN_BITS-1:1]} : off_q;
      drv_lo = in_cyc && we_q;
      drv_hi = in_cyc && we_q && is_wide;
      rdy    = (phase == PH_DONE);
   end
endmodule

// File: rtl/amc_async_mem.sv
module amc_async_mem
   import amc_pkg::*;
#(
   parameter int NCS         = 4,
   parameter int WIN_BITS    = 26,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W    = (NCS > 1) ? $clog2(NCS) : 1,
   localparam int ADDR_W   = WIN_BITS + SEL_W,
   localparam int NARROW_W = DATA_W / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_req,
   input  logic                 host_we,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   output logic                 host_rdy,
   output logic [NCS-1:0]       mem_cs_n,
   output logic                 mem_oe_n,
   output logic                 mem_we_n,
   output logic [WIN_BITS-1:0]  mem_addr,
   inout  wire  [DATA_W-1:0]    mem_data,
   input  logic [NCS-1:0]       mem_wait,
   input  logic [NCS*CNT_W-1:0] cfg_rd_setup,
   input  logic [NCS*CNT_W-1:0] cfg_rd_strobe,
   input  logic [NCS*CNT_W-1:0] cfg_rd_hold,
   input  logic [NCS*CNT_W-1:0] cfg_wr_setup,
   input  logic [NCS*CNT_W-1:0] cfg_wr_strobe,
   input  logic [NCS*CNT_W-1:0] cfg_wr_hold,
   input  logic [NCS*CNT_W-1:0] cfg_turn,
   input  logic [NCS-1:0]       cfg_wide,
   input  logic [NCS-1:0]       cfg_sel_strobe,
   input  logic [NCS-1:0]       cfg_ext_wait
);
   if (NCS < 2 || (1 << SEL_W) != NCS) begin : g_bad_ncs
      $error("NCS must be a power of two of at least 2");
   end
   if (DATA_W < 2 || DATA_W % 2 != 0) begin : g_bad_width
      $error("DATA_W must be even");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || WIN_BITS < 2) begin : g_bad_cnt
      $error("CNT_W and WIN_BITS too small");
   end

   logic [SEL_W-1:0]    cs_q;
   logic                we_q;
   phase_t              phase;
   logic [CNT_W-1:0]    setup_lim, strobe_lim, hold_lim, turn_cnt;
   logic                is_wide, is_ss, is_ew;
   logic [NCS-1:0]      wait_s;
   logic [DATA_W-1:0]   dout;
   logic                drv_lo, drv_hi;

   amc_wait_sync #(.N(NCS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mem_wait), .dout(wait_s)
   );

   amc_cfg_sel #(.NCS(NCS), .CNT_W(CNT_W)) u_cfg (
      .sel(cs_q), .we(we_q),
      .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
      .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
      .turn(cfg_turn), .wide(cfg_wide), .sel_strobe(cfg_sel_strobe),
      .ext_wait(cfg_ext_wait),
      .setup_lim(setup_lim), .strobe_lim(strobe_lim), .hold_lim(hold_lim),
      .turn_cnt(turn_cnt), .is_wide(is_wide), .is_ss(is_ss), .is_ew(is_ew)
   );

   amc_seq_fsm #(
      .NCS(NCS), .CNT_W(CNT_W), .WIN_BITS(WIN_BITS),
      .DATA_W(DATA_W), .NARROW_W(NARROW_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req(host_req), .req_we(host_we),
      .req_cs(host_addr[ADDR_W-1:WIN_BITS]), .req_off(host_addr[WIN_BITS-1:0]),
      .req_wdata(host_wdata),
      .setup_lim(setup_lim), .strobe_lim(strobe_lim), .hold_lim(hold_lim),
      .turn_cnt(turn_cnt), .is_wide(is_wide), .is_ss(is_ss), .is_ew(is_ew),
      .wait_s(wait_s), .din(mem_data),
      .cs_q(cs_q), .we_q(we_q), .phase(phase),
      .cs_n(mem_cs_n), .oe_n(mem_oe_n), .wen_n(mem_we_n), .addr(mem_addr),
      .dout(dout), .drv_lo(drv_lo), .drv_hi(drv_hi),
      .rdata(host_rdata), .rdy(host_rdy)
   );

   assign mem_data[NARROW_W-1:0]      = drv_lo ? dout[NARROW_W-1:0]      : {NARROW_W{1'bz}};
   assign mem_data[DATA_W-1:NARROW_W] = drv_hi ? dout[DATA_W-1:NARROW_W] : {(DATA_W-NARROW_W){1'bz}};
endmodule

// File: rtl/amc_async_mem_chk.sv
module amc_async_mem_chk
   import amc_pkg::*;
#(
   parameter int NCS      = 4,
   parameter int WIN_BITS = 26
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NCS-1:0]      mem_cs_n,
   input logic                mem_oe_n,
   input logic                mem_we_n,
   input logic [WIN_BITS-1:0] mem_addr,
   input logic                host_rdy,
   input logic                drv_lo,
   input phase_t              phase
);
   p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   p_strobe_has_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

   p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> $stable(mem_addr));

   p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drv_lo |-> mem_oe_n);

   p_rdy_after_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdy) |-> $past(phase) == PH_HOLD);

   p_rdy_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdy |=> !host_rdy);
endmodule

bind amc_async_mem amc_async_mem_chk #(.NCS(NCS), .WIN_BITS(WIN_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
   .mem_we_n(mem_we_n), .mem_addr(mem_addr), .host_rdy(host_rdy),
   .drv_lo(drv_lo), .phase(phase)
);

// File: tb/amc_async_mem_tb.sv
module amc_async_mem_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [27:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_rdy;
   logic [3:0]  mem_cs_n;
   logic        mem_oe_n, mem_we_n;
   logic [25:0] mem_addr;
   wire  [15:0] mem_data;
   logic [3:0]  mem_wait = '0;
   logic [15:0] rd_val = '0;

   // chip select fields {cs3, cs2, cs1, cs0}
   logic [15:0] c_rsu = 16'h1202, c_rst = 16'h2203, c_rho = 16'h1201;
   logic [15:0] c_wsu = 16'h1201, c_wst = 16'h2202, c_who = 16'h1202;
   logic [15:0] c_turn = 16'h1203;
   logic [3:0]  c_wide = 4'b0101, c_ss = 4'b0100, c_ew = 4'b1000;

   int n_tests = 0, n_fail = 0;
   int m_lat, m_setup, m_strobe, m_hold, m_total, m_cs_seen, m_cs_out, m_cs_stb, m_badstb;
   logic [25:0] m_addr;
   logic [15:0] m_d_first, m_d_strobe, m_d_last, m_rdata;
   logic        m_rdy_next, m_timeout;

   always #4 clk = ~clk;

   assign mem_data = mem_oe_n ? 16'hzzzz : rd_val;

   amc_async_mem u_dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rdy(host_rdy), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_data(mem_data),
      .mem_wait(mem_wait), .cfg_rd_setup(c_rsu), .cfg_rd_strobe(c_rst),
      .cfg_rd_hold(c_rho), .cfg_wr_setup(c_wsu), .cfg_wr_strobe(c_wst),
      .cfg_wr_hold(c_who), .cfg_turn(c_turn), .cfg_wide(c_wide),
      .cfg_sel_strobe(c_ss), .cfg_ext_wait(c_ew)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // one access; rel_at > 0 raises the wait bit first and drops it in strobe cycle rel_at
   task automatic run_acc(input logic we, input logic [1:0] cs, input logic [25:0] off,
                          input logic [15:0] wd, input int rel_at, input logic [15:0] rbase);
      bit started = 0, seen_stb = 0;
      m_lat = 0; m_setup = 0; m_strobe = 0; m_hold = 0; m_total = 0; m_cs_seen = -1;
      m_cs_out = 0; m_cs_stb = 0; m_badstb = 0; m_timeout = 1;
      if (rel_at > 0) begin
         mem_wait[cs] = 1'b1;
         repeat (2) @(negedge clk);
      end
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = {cs, off}; host_wdata = wd;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         m_total++;
         if (host_rdy) begin
            m_rdata = host_rdata; host_req = 1'b0; m_timeout = 0;
            break;
         end
         if (!mem_oe_n || !mem_we_n) begin
            started = 1; seen_stb = 1; m_strobe++;
            m_addr = mem_addr;
            if (we != mem_oe_n || we == mem_we_n) m_badstb++;
            for (int k = 0; k < 4; k++) if (!mem_cs_n[k]) m_cs_seen = k;
            if (mem_cs_n != 4'hf) m_cs_stb++;
            if (we) m_d_strobe = mem_data;
            else rd_val = rbase + 16'(m_strobe);
            if (m_strobe == rel_at) mem_wait[cs] = 1'b0;
         end else if (mem_cs_n != 4'hf) begin
            started = 1; m_cs_out++;
            if (!seen_stb) begin
               m_setup++;
               if (m_setup == 1) m_d_first = mem_data;
            end else begin
               m_hold++; m_d_last = mem_data;
            end
         end else if (!started) m_lat++;
      end
      @(negedge clk);
      m_rdy_next = host_rdy;
      if (m_timeout) chk(0, "watchdog(access)", 0, 1);
   endtask

   task automatic t_reset();
      chk(mem_cs_n == 4'hf, "R10 cs_n", mem_cs_n, 4'hf);
      chk(mem_oe_n && mem_we_n, "R10 strobes", {mem_oe_n, mem_we_n}, 3);
      chk(!host_rdy, "R10 rdy", host_rdy, 0);
   endtask

   task automatic t_read_wide();
      run_acc(0, 2'd0, 26'h0000ABC, 16'h0, 0, 16'hBE00);
      chk(m_lat == 0, "R4 first access no turn", m_lat, 0);
      chk(m_setup == 2 && m_strobe == 3 && m_hold == 1, "R2 read phases",
          m_setup*100 + m_strobe*10 + m_hold, 231);
      chk(m_cs_seen == 0, "R1 cs0", m_cs_seen, 0);
      chk(m_badstb == 0, "R2 read uses oe only", m_badstb, 0);
      chk(m_addr == 26'h000055E, "R7 wide address", m_addr, 26'h55E);
      chk(m_rdata == 16'hBE03, "R9 capture final strobe", m_rdata, 16'hBE03);
      chk(m_rdy_next == 0, "R9 single pulse", m_rdy_next, 0);
      chk(m_total == 7, "R9 rdy after hold", m_total, 7);
      run_acc(0, 2'd0, 26'h0000010, 16'h0, 0, 16'h1100);
      chk(m_lat == 0, "R4 read-read same cs", m_lat, 0);
      chk(m_rdata == 16'h1103, "R9 held data", m_rdata, 16'h1103);
   endtask

   task automatic t_write_wide();
      run_acc(1, 2'd0, 26'h0000020, 16'h1234, 0, 16'h0);
      chk(m_lat == 3, "R4 direction change", m_lat, 3);
      chk(m_setup == 1 && m_strobe == 2 && m_hold == 2, "R2 write phases",
          m_setup*100 + m_strobe*10 + m_hold, 122);
      chk(m_badstb == 0, "R2 write uses we only", m_badstb, 0);
      chk(m_d_first == 16'h1234 && m_d_strobe == 16'h1234 && m_d_last == 16'h1234,
          "R8 write data span", m_d_last, 16'h1234);
      chk(m_addr == 26'h10, "R7 wide write addr", m_addr, 26'h10);
   endtask

   task automatic t_narrow();
      run_acc(1, 2'd1, 26'h3FFFFFF, 16'h56A7, 0, 16'h0);
      chk(m_lat == 3, "R4 cs change uses previous turn", m_lat, 3);
      chk(m_setup == 1 && m_strobe == 1 && m_hold == 1, "R3 zero counts write",
          m_setup*100 + m_strobe*10 + m_hold, 111);
      chk(m_cs_seen == 1, "R1 cs1", m_cs_seen, 1);
      chk(m_addr == 26'h3FFFFFF, "R7 narrow addr top of window", m_addr, 26'h3FFFFFF);
      chk(m_d_strobe[7:0] == 8'hA7, "R7 narrow low byte", m_d_strobe[7:0], 8'hA7);
      run_acc(0, 2'd1, 26'h0000005, 16'h0, 0, 16'hA5C0);
      chk(m_lat == 0, "R4 zero turnaround", m_lat, 0);
      chk(m_setup == 1 && m_strobe == 1 && m_hold == 1, "R3 zero counts read",
          m_setup*100 + m_strobe*10 + m_hold, 111);
      chk(m_rdata == 16'h00C1, "R7 narrow read upper zero", m_rdata, 16'h00C1);
   endtask

   task automatic t_sel_strobe();
      run_acc(0, 2'd2, 26'h0000100, 16'h0, 0, 16'h2200);
      chk(m_cs_out == 0, "R5 cs outside strobe", m_cs_out, 0);
      chk(m_cs_stb == 2 && m_strobe == 2, "R5 cs during strobe", m_cs_stb, 2);
      chk(m_total == 7, "R5 setup+hold kept", m_total, 7);
      chk(m_cs_seen == 2, "R1 cs2", m_cs_seen, 2);
   endtask

   task automatic t_wait();
      run_acc(0, 2'd3, 26'h0000040, 16'h0, 4, 16'h7700);
      chk(m_strobe == 6, "R6 wait extends strobe", m_strobe, 6);
      chk(m_rdata == 16'h0006, "R9 capture on stretched strobe", m_rdata, 16'h0006);
      run_acc(0, 2'd0, 26'h0000002, 16'h0, 99, 16'h3300);
      mem_wait = '0;
      chk(m_strobe == 3, "R6 wait ignored when mode off", m_strobe, 3);
      chk(m_lat == 1, "R4 turn of cs3", m_lat, 1);
      run_acc(0, 2'd3, 26'h0000041, 16'h0, 0, 16'h0);
      chk(m_strobe == 2, "R6 no wait programmed length", m_strobe, 2);
      chk(m_lat == 3, "R4 turn of cs0", m_lat, 3);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_read_wide();
      t_write_wide();
      t_narrow();
      t_sel_strobe();
      t_wait();
      summary();
      $finish;
   end
endmodule